// File: doc/BRIEF.md
# Two-Point ADC Code Calibration Datapath

This block turns a raw converter code into a corrected reading for one input channel. It corrects the code with a linear model built from two factory trim values, then scales it into output units. A setup request captures the two trim deviations (d1, d2), the low and high ideal codes (x1, x2) and the expected low and high readings (v1, v2). From these it derives three terms:
- a gain-error factor k = 1000 + 1000*(d2-d1)/(x2-x1), in thousandths;
- a scale gain g = 1000*(v2-v1)/(x2-x1), in thousandths;
- an offset = 1000*d1 - (k-1000)*x1.

For a calibrated channel the corrected code is c = (1000*raw - offset)/k. The output is c*g/1000. A channel with no calibration data sets the bypass input: the correction step is then skipped and only the gain scaling is applied. All intermediate values are signed 32-bit. Every division truncates toward zero and runs on one shared radix-2 restoring divider. A negative corrected code clamps the output to zero and raises a mismatch flag.

A setup or a conversion runs for several divider passes. `busy` is high while it runs. A one-cycle `done` pulse marks the end.

Top module: `adc_cal_top`

## Requirements
- R1: After synchronous reset, busy, done, mismatch and overrun are 0 and result is 0.
- R2: A setup request (cfg_start while idle) computes k, g and offset from the formulas above with truncating division, and a following conversion uses them.
- R3: The raw code is bits [11:0] of sample_word; bits [15:12] have no effect. For a calibrated channel c = (1000*raw - offset)/k, truncated toward zero, so a small negative quotient becomes 0 without mismatch.
- R4: A conversion with c >= 0 gives result = c*g/1000, truncated toward zero, with mismatch 0.
- R5: If c < 0, result is 0 and mismatch is 1. mismatch is cleared again by the next conversion with c >= 0.
- R6: With bypass = 1, c = raw and result = raw*g/1000.
- R7: done is high for exactly one cycle when a setup or conversion ends. busy is high from the cycle after acceptance until done, and busy is 0 in the done cycle.
- R8: A sample_valid pulse while busy is ignored, so the running conversion's result is unaffected. It sets overrun, which stays 1 until reset.
- R9: result changes only in a cycle where done is 1. A setup leaves result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Setup request; takes priority over a sample in the same idle cycle |
| trim_lo | input | 16 | First trim deviation d1, signed |
| trim_hi | input | 16 | Second trim deviation d2, signed |
| ideal_lo | input | 16 | Low ideal code x1 |
| ideal_hi | input | 16 | High ideal code x2 |
| read_lo | input | 16 | Expected low reading v1 |
| read_hi | input | 16 | Expected high reading v2 |
| bypass | input | 1 | 1: channel has no calibration, skip correction |
| sample_valid | input | 1 | Raw sample strobe |
| sample_word | input | 16 | Converter result word, code in bits [11:0] |
| busy | output | 1 | Setup or conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Scaled reading, signed |
| mismatch | output | 1 | Last conversion had a negative corrected code |
| overrun | output | 1 | A sample arrived while busy (sticky) |

## Verification
Some rules can be checked on every cycle, and the assertions do so. These are the single-cycle done pulse from both the divider and the sequencer, and busy being low whenever done is high. They also cover result moving only on done, a zero result whenever mismatch completes a conversion, and overrun being set by a busy-time sample and then holding. The arithmetic itself only shows in the bench's scenarios. These cover the calibration formulas, truncation toward zero of negative trim differences and of small negative corrected codes, the masking of the upper word bits, bypass scaling, mismatch clearing, and a dropped busy-time sample not disturbing the running result.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
    localparam int DW     = 32;
    localparam int RAW_W  = 12;
    localparam int WORD_W = 16;
    localparam int TRIM_W = 16;
    localparam int PT_W   = 16;
    localparam int SCALE  = 1000;

    typedef logic signed [DW-1:0] sword_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_K,
        ST_G,
        ST_OFF,
        ST_COR,
        ST_SCL
    } cal_st_e;

    typedef struct packed {
        sword_t k;
        sword_t gain;
        sword_t offset;
    } coef_t;

    function automatic sword_t raw_code(input logic [WORD_W-1:0] word);
        return sword_t'({{(DW-RAW_W){1'b0}}, word[RAW_W-1:0]});
    endfunction

    function automatic sword_t corr_num(input sword_t raw, input sword_t off);
        return raw * SCALE - off;
    endfunction
endpackage

// File: rtl/adc_cal_div.sv
module adc_cal_div #(
    parameter int W = adc_cal_pkg::DW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic signed [W-1:0] num,
    input  logic signed [W-1:0] den,
    output logic                busy,
    output logic                done,
    output logic signed [W-1:0] quot
);
    localparam int CW = $clog2(W + 1);

    logic          neg;
    logic [W-1:0]  mag_d;
    logic [W-1:0]  quo;
    logic [W:0]    rem;
    logic [CW-1:0] cnt;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    assign shifted = {rem[W-1:0], quo[W-1]};
    assign trial   = shifted - {1'b0, mag_d};
    assign quot    = neg ? -$signed(quo) : $signed(quo);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            neg   <= 1'b0;
            mag_d <= '0;
            quo   <= '0;
            rem   <= '0;
            cnt   <= '0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                busy  <= 1'b1;
                neg   <= num[W-1] ^ den[W-1];
                quo   <= num[W-1] ? W'(-num) : W'(num);
                mag_d <= den[W-1] ? W'(-den) : W'(den);
                rem   <= '0;
                cnt   <= CW'(W);
            end else if (busy) begin
                if (!trial[W]) begin
                    rem <= trial;
                    quo <= {quo[W-2:0], 1'b1};
                end else begin
                    rem <= shifted;
                    quo <= {quo[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_DIV_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_DIV_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R7
endmodule

// File: rtl/adc_cal_coef.sv
module adc_cal_coef
    import adc_cal_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic signed [TRIM_W-1:0] trim_lo,
    input  logic signed [TRIM_W-1:0] trim_hi,
    input  logic [PT_W-1:0]          ideal_lo,
    input  logic [PT_W-1:0]          ideal_hi,
    input  logic [PT_W-1:0]          read_lo,
    input  logic [PT_W-1:0]          read_hi,
    input  logic                     k_we,
    input  logic                     g_we,
    input  logic                     off_we,
    input  sword_t                   div_q,
    output coef_t                    coef,
    output sword_t                   num_k,
    output sword_t                   num_g,
    output sword_t                   den
);
    sword_t d1, d2, x1, x2, v1, v2;

    assign num_k = (d2 - d1) * SCALE;
    assign num_g = (v2 - v1) * SCALE;
    assign den   = x2 - x1;

    always_ff @(posedge clk) begin
        if (rst) begin
            d1 <= '0; d2 <= '0; x1 <= '0; x2 <= '0; v1 <= '0; v2 <= '0;
            coef.k      <= sword_t'(SCALE);
            coef.gain   <= sword_t'(SCALE);
            coef.offset <= '0;
        end else begin
            if (load) begin
                d1 <= DW'(trim_lo);
                d2 <= DW'(trim_hi);
                x1 <= sword_t'({{(DW-PT_W){1'b0}}, ideal_lo});
                x2 <= sword_t'({{(DW-PT_W){1'b0}}, ideal_hi});
                v1 <= sword_t'({{(DW-PT_W){1'b0}}, read_lo});
                v2 <= sword_t'({{(DW-PT_W){1'b0}}, read_hi});
            end
            if (k_we)   coef.k      <= sword_t'(SCALE) + div_q;
            if (g_we)   coef.gain   <= div_q;
            if (off_we) coef.offset <= d1 * SCALE - (coef.k - sword_t'(SCALE)) * x1;
        end
    end
endmodule

// File: rtl/adc_cal_top.sv
module adc_cal_top
    import adc_cal_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_start,
    input  logic signed [TRIM_W-1:0] trim_lo,
    input  logic signed [TRIM_W-1:0] trim_hi,
    input  logic [PT_W-1:0]          ideal_lo,
    input  logic [PT_W-1:0]          ideal_hi,
    input  logic [PT_W-1:0]          read_lo,
    input  logic [PT_W-1:0]          read_hi,
    input  logic                     bypass,
    input  logic                     sample_valid,
    input  logic [WORD_W-1:0]        sample_word,
    output logic                     busy,
    output logic                     done,
    output logic signed [DW-1:0]     result,
    output logic                     mismatch,
    output logic                     overrun
);
    cal_st_e state;
    coef_t   coef;
    sword_t  num_k, num_g, den;
    sword_t  div_a, div_b, div_q;
    logic    div_go, div_busy, div_done;
    logic    cfg_load, k_we, g_we, off_we;

    assign busy     = (state != ST_IDLE);
    assign cfg_load = (state == ST_IDLE) && cfg_start;
    assign k_we     = (state == ST_K) && div_done;
    assign g_we     = (state == ST_G) && div_done;
    assign off_we   = (state == ST_OFF);

    adc_cal_coef i_coef (
        .clk(clk), .rst(rst), .load(cfg_load),
        .trim_lo(trim_lo), .trim_hi(trim_hi),
        .ideal_lo(ideal_lo), .ideal_hi(ideal_hi),
        .read_lo(read_lo), .read_hi(read_hi),
        .k_we(k_we), .g_we(g_we), .off_we(off_we), .div_q(div_q),
        .coef(coef), .num_k(num_k), .num_g(num_g), .den(den)
    );

    adc_cal_div #(.W(DW)) i_div (
        .clk(clk), .rst(rst), .go(div_go), .num(div_a), .den(div_b),
        .busy(div_busy), .done(div_done), .quot(div_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            div_go   <= 1'b0;
            div_a    <= '0;
            div_b    <= '0;
            done     <= 1'b0;
            result   <= '0;
            mismatch <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            div_go <= 1'b0;
            done   <= 1'b0;
            if (sample_valid && busy) overrun <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (cfg_start) begin
                        state <= ST_LOAD;
                    end else if (sample_valid) begin
                        mismatch <= 1'b0;
                        div_go   <= 1'b1;
                        if (bypass) begin
                            div_a <= raw_code(sample_word) * coef.gain;
                            div_b <= sword_t'(SCALE);
                            state <= ST_SCL;
                        end else begin
                            div_a <= corr_num(raw_code(sample_word), coef.offset);
                            div_b <= coef.k;
                            state <= ST_COR;
                        end
                    end
                end
                ST_LOAD: begin
                    div_a  <= num_k;
                    div_b  <= den;
                    div_go <= 1'b1;
                    state  <= ST_K;
                end
                ST_K: if (div_done) begin
                    div_a  <= num_g;
                    div_b  <= den;
                    div_go <= 1'b1;
                    state  <= ST_G;
                end
                ST_G: if (div_done) state <= ST_OFF;
                ST_OFF: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                ST_COR: if (div_done) begin
                    if (div_q < 0) begin
                        result   <= '0;
                        mismatch <= 1'b1;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        div_a  <= div_q * coef.gain;
                        div_b  <= sword_t'(SCALE);
                        div_go <= 1'b1;
                        state  <= ST_SCL;
                    end
                end
                ST_SCL: if (div_done) begin
                    result <= div_q;
                    done   <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R7
    AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done); // R9
    AST_MISMATCH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && mismatch) |-> (result == 0)); // R5
    AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
        (busy && sample_valid) |=> overrun); // R8
    AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R8
endmodule

// File: tb/test_adc_cal_top.sv
`timescale 1ns/1ps
module test_adc_cal_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_start = 1'b0;
    logic signed [15:0] trim_lo = '0, trim_hi = '0;
    logic [15:0] ideal_lo = 16'd2064, ideal_hi = 16'd3112;
    logic [15:0] read_lo = '0, read_hi = '0;
    logic bypass = 1'b0, sample_valid = 1'b0;
    logic [15:0] sample_word = '0;
    logic busy, done, mismatch, overrun;
    logic signed [31:0] result;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    adc_cal_top i_adc_cal_top (
        .clk(clk), .rst(rst), .cfg_start(cfg_start),
        .trim_lo(trim_lo), .trim_hi(trim_hi),
        .ideal_lo(ideal_lo), .ideal_hi(ideal_hi),
        .read_lo(read_lo), .read_hi(read_hi),
        .bypass(bypass), .sample_valid(sample_valid), .sample_word(sample_word),
        .busy(busy), .done(done), .result(result),
        .mismatch(mismatch), .overrun(overrun)
    );

    // d1, d2, v1, v2, bypass, sample word
    localparam int VEC [8][6] = '{
        '{5,   12,  630,  950,  0, 'h0810},
        '{5,   12,  630,  950,  0, 'hFC28},
        '{100, 90,  630,  950,  0, 'h0064},
        '{-3,  4,   1260, 1900, 0, 'h0FFF},
        '{0,   0,   2520, 3800, 1, 'h0FFF},
        '{20,  -15, 3150, 4750, 0, 'h0400},
        '{5,   12,  630,  950,  0, 'h0000},
        '{3,   5,   630,  950,  0, 'h0000}
    };

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cycles);
            summary();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void model(input int d1, input int d2, input int v1, input int v2,
                                  input int byp, input int word,
                                  output int res, output int mm);
        int k, g, off, raw, c;
        k   = 1000 + (1000 * (d2 - d1)) / (3112 - 2064);
        g   = (1000 * (v2 - v1)) / (3112 - 2064);
        off = d1 * 1000 - (k - 1000) * 2064;
        raw = word & 'hFFF;
        c   = byp ? raw : (raw * 1000 - off) / k;
        if (c < 0) begin res = 0; mm = 1; end
        else begin res = (c * g) / 1000; mm = 0; end
    endfunction

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic setup(input int d1, input int d2, input int v1, input int v2);
        trim_lo = 16'(d1); trim_hi = 16'(d2);
        read_lo = 16'(v1); read_hi = 16'(v2);
        cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        wait_done();
        @(negedge clk);
    endtask

    task automatic convert(input int byp, input int word);
        bypass = byp[0];
        sample_word = 16'(word);
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        wait_done();
    endtask

    initial begin
        int er, em, held;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 result", result, 0);
        chk("R1 mismatch", mismatch, 0);
        chk("R1 overrun", overrun, 0);

        // R2 R3 R4 R5 R6: table walk
        foreach (VEC[i]) begin
            setup(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
            convert(VEC[i][4], VEC[i][5]);
            model(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], VEC[i][5], er, em);
            chk($sformatf("R2/R3/R4/R6 result vec%0d", i), result, er);
            chk($sformatf("R5 mismatch vec%0d", i), mismatch, em);
            @(negedge clk);
        end

        // R7 done pulse and busy
        convert(0, 'h0800);
        chk("R7 busy low in done cycle", busy, 0);
        @(negedge clk);
        chk("R7 done one cycle", done, 0);

        // R9 setup leaves result unchanged
        held = result;
        setup(5, 12, 630, 950);
        chk("R9 result after setup", result, held);

        // R8 overrun and ignored sample
        chk("R8 overrun clear before", overrun, 0);
        bypass = 1'b0; sample_word = 16'h0C00; sample_valid = 1'b1;
        @(negedge clk);
        sample_word = 16'h0001;
        @(negedge clk);
        chk("R7 busy while converting", busy, 1);
        sample_valid = 1'b0;
        wait_done();
        model(5, 12, 630, 950, 0, 'h0C00, er, em);
        chk("R8 busy sample ignored", result, er);
        chk("R8 overrun set", overrun, 1);
        @(negedge clk);
        convert(1, 'h0100);
        model(5, 12, 630, 950, 1, 'h0100, er, em);
        chk("R6 bypass result", result, er);
        chk("R8 overrun sticky", overrun, 1);
        @(negedge clk);
        summary();
    end
endmodule